// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a four-beat burst. An accepted address strobe captures the full word address. The strobe can come from either of two sources: a processor-side strobe and a controller-side strobe. The two least significant bits become the starting offset of the burst. The upper bits are held for the rest of the burst. On each later clock where the advance input is high, the block moves to the next beat. The two offset bits are then recomputed, and the upper bits stay fixed.

The order of the offsets is chosen by an order-select input, which is captured together with the address. In interleaved order, beat k uses the start offset XOR k. In linear order, beat k uses (start + k) modulo 4. A small state machine sits behind the beat counter and has two states. `ST_IDLE` is the state after reset, before any strobe has been accepted. `ST_ACTIVE` is the state in which a burst is loaded. Its transitions are:

- **LOAD**: from either state to `ST_ACTIVE` on any strobe.
- **STEP**: in `ST_ACTIVE`, on advance with no strobe.
- **HOLD**: in `ST_ACTIVE`, with neither strobe nor advance.
- **WAIT**: in `ST_IDLE`, without a strobe.

Top module: `burst_seq_gen`

## Requirements
- R1: While reset is held and right after it is released, the state is `ST_IDLE`, and `burst_ofs` and `burst_addr` are all zero.
- R2: A clock edge with `strobe_cpu` or `strobe_ctl` high (either or both) loads the burst. From the next cycle, `burst_ofs` equals `addr_in[1:0]` sampled at that edge.
- R3: With `order_sel` = 1 captured at load (interleaved), the offset after k advances is start XOR (k mod 4).
- R4: With `order_sel` = 0 captured at load (linear), the offset after k advances is (start + k) mod 4.
- R5: In `ST_ACTIVE`, an edge with no strobe and `advance` low leaves `burst_ofs` and `burst_addr` unchanged.
- R6: When a strobe and `advance` are both high on the same edge, the strobe wins. The burst reloads at beat 0 from the new `addr_in`.
- R7: `burst_addr[ADDR_W-1:2]` equals the upper bits of `addr_in` captured at the last load. Advances never change them, and `burst_addr[1:0]` equals `burst_ofs`.
- R8: In `ST_IDLE`, `advance` without a strobe has no effect, and the outputs stay zero.
- R9: After four advances the offset returns to the start offset, and further advances repeat the same four-entry sequence.
- R10: `order_sel` is sampled only on a loading edge. Changing it during a burst does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for every input |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_cpu | input | 1 | Processor-side address strobe |
| strobe_ctl | input | 1 | Controller-side address strobe |
| advance | input | 1 | Step to the next beat |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order (sampled at load) |
| addr_in | input | ADDR_W | External word address |
| burst_addr | output | ADDR_W | Current burst word address |
| burst_ofs | output | 2 | Current low offset bits |

## Verification
The assertions watch several behaviours on every cycle:

- the beat counter moves up by exactly one on each advance;
- the counter stays at zero in `ST_IDLE`;
- a strobe loads the low offset and the upper bits;
- a hold cycle leaves the outputs unchanged;
- outputs stay zero while idle.

Only the bench scenarios show the actual interleaved and linear orders, including the wrap after four beats. They also show that a mid-burst change of `order_sel` is ignored and that a strobe wins over a simultaneous advance. The bench covers these with directed sequences and a long random stream, compared against a behavioural model on every clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } burst_state_e;

    typedef enum logic [0:0] {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    output burst_state_e     state,
    output logic [OFS_W-1:0] beat
);

    localparam logic [OFS_W-1:0] BEAT_ONE  = OFS_W'(1);
    localparam logic [OFS_W-1:0] BEAT_ZERO = '0;

    burst_state_e     state_q, state_d;
    logic [OFS_W-1:0] beat_q,  beat_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: LOAD, STEP, HOLD, WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load) begin
                    state_d = ST_ACTIVE;       // LOAD
                end else begin
                    state_d = ST_IDLE;         // WAIT
                end
            end
            ST_ACTIVE: begin
                state_d = ST_ACTIVE;           // LOAD, STEP or HOLD
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Beat counter (output process)
    always_comb begin
        beat_d = beat_q;
        unique case (state_q)
            ST_IDLE: begin
                beat_d = BEAT_ZERO;
            end
            ST_ACTIVE: begin
                if (load) begin
                    beat_d = BEAT_ZERO;
                end else if (advance) begin
                    beat_d = beat_q + BEAT_ONE;
                end else begin
                    beat_d = beat_q;
                end
            end
            default: beat_d = BEAT_ZERO;
        endcase
        if (load) begin
            beat_d = BEAT_ZERO;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= BEAT_ZERO;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign state = state_q;
    assign beat  = beat_q;

    // R3 R4 R9: each advance moves the counter up by one, wrapping
    p_step_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !load && advance) |=> (beat_q == $past(beat_q) + BEAT_ONE));

    // R8: the counter stays at zero while idle
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (beat_q == BEAT_ZERO));

    // R6: a strobe restarts at beat zero
    p_reload_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_q == BEAT_ZERO && state_q == ST_ACTIVE));

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int OFS_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    order_sel,
    input  logic [ADDR_W-1:0]       addr_in,
    output logic [ADDR_W-OFS_W-1:0] upper,
    output logic [OFS_W-1:0]        start,
    output burst_order_e            order
);

    localparam int UPPER_W = ADDR_W - OFS_W;

    logic [UPPER_W-1:0] upper_q;
    logic [OFS_W-1:0]   start_q;
    burst_order_e       order_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            order_q <= ORD_LINEAR;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:OFS_W];
            start_q <= addr_in[OFS_W-1:0];
            order_q <= burst_order_e'(order_sel);
        end
    end

    assign upper = upper_q;
    assign start = start_q;
    assign order = order_q;

    // R10: the captured order only changes on a load
    p_order_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(order_q));

endmodule

// File: rtl/burst_ofs_map.sv
module burst_ofs_map
    import burst_seq_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0] start,
    input  logic [OFS_W-1:0] beat,
    input  burst_order_e     order,
    output logic [OFS_W-1:0] ofs
);

    logic [OFS_W-1:0] ofs_xor;
    logic [OFS_W-1:0] ofs_lin;

    // Interleaved order: one XOR per offset bit
    for (genvar i = 0; i < OFS_W; i++) begin : g_xor_bit
        assign ofs_xor[i] = start[i] ^ beat[i];
    end

    // Linear order: modular add inside the offset width
    assign ofs_lin = start + beat;

    always_comb begin
        unique case (order)
            ORD_INTERLEAVE: ofs = ofs_xor;
            ORD_LINEAR:     ofs = ofs_lin;
            default:        ofs = ofs_lin;
        endcase
    end

endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              advance,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] burst_addr,
    output logic [OFS_W-1:0]  burst_ofs
);

    localparam int UPPER_W = ADDR_W - OFS_W;

    logic               load;
    burst_state_e       state;
    logic [OFS_W-1:0]   beat;
    logic [UPPER_W-1:0] upper;
    logic [OFS_W-1:0]   start;
    burst_order_e       order;
    logic [OFS_W-1:0]   ofs;

    assign load = strobe_cpu | strobe_ctl;

    burst_seq_fsm #(.OFS_W(OFS_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .state   (state),
        .beat    (beat)
    );

    burst_addr_reg #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_areg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .upper     (upper),
        .start     (start),
        .order     (order)
    );

    burst_ofs_map #(.OFS_W(OFS_W)) u_map (
        .start (start),
        .beat  (beat),
        .order (order),
        .ofs   (ofs)
    );

    assign burst_ofs  = ofs;
    assign burst_addr = {upper, ofs};

    // R2: a strobe from either source loads the start offset
    p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_cpu || strobe_ctl) |=> (burst_ofs == $past(addr_in[OFS_W-1:0])));

    // R7: upper bits come from the address captured at load
    p_upper_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_cpu || strobe_ctl) |=> (burst_addr[ADDR_W-1:OFS_W] == $past(addr_in[ADDR_W-1:OFS_W])));

    // R7: advancing never touches the upper bits
    p_upper_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_cpu || strobe_ctl) |=> $stable(burst_addr[ADDR_W-1:OFS_W]));

    // R5: hold cycles leave the outputs alone
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && !strobe_cpu && !strobe_ctl && !advance) |=> ($stable(burst_ofs) && $stable(burst_addr)));

    // R8: idle with no strobe keeps the outputs at zero
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !strobe_cpu && !strobe_ctl) |=> (burst_addr == '0));

endmodule

// File: tb/burst_seq_gen_tb.sv
module burst_seq_gen_tb;

    localparam int  ADDR_W     = 18;
    localparam int  OFS_W      = 2;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strobe_cpu = 1'b0;
    logic              strobe_ctl = 1'b0;
    logic              advance = 1'b0;
    logic              order_sel = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] burst_addr;
    logic [OFS_W-1:0]  burst_ofs;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural reference state
    bit    m_active = 0;
    int    m_start  = 0;
    int    m_beat   = 0;
    bit    m_inter  = 0;
    int    m_upper  = 0;
    string m_tag    = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_seq_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_cpu (strobe_cpu),
        .strobe_ctl (strobe_ctl),
        .advance    (advance),
        .order_sel  (order_sel),
        .addr_in    (addr_in),
        .burst_addr (burst_addr),
        .burst_ofs  (burst_ofs)
    );

    function automatic int exp_ofs();
        if (!m_active) return 0;
        if (m_inter)   return m_start ^ (m_beat % 4);
        return (m_start + m_beat) % 4;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare outputs at the falling edge, then drive the next inputs and advance the model
    task automatic step(bit cpu, bit ctl, bit adv, bit ord, int addr);
        @(negedge clk);
        check(m_tag, int'(burst_ofs), exp_ofs());
        check("R7", int'(burst_addr), (m_active ? m_upper * 4 : 0) + exp_ofs());
        strobe_cpu = cpu;
        strobe_ctl = ctl;
        advance    = adv;
        order_sel  = ord;
        addr_in    = ADDR_W'(addr);
        if (cpu || ctl) begin
            m_tag    = adv ? "R6" : "R2";
            m_active = 1;
            m_start  = addr % 4;
            m_upper  = (addr / 4) % (1 << (ADDR_W - OFS_W));
            m_inter  = ord;
            m_beat   = 0;
        end else if (!m_active) begin
            m_tag = "R8";
        end else if (adv) begin
            m_beat = m_beat + 1;
            if (ord != m_inter)         m_tag = "R10";
            else if (m_beat % 4 == 0)   m_tag = "R9";
            else                        m_tag = m_inter ? "R3" : "R4";
        end else begin
            m_tag = "R5";
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", int'(burst_addr), 0);
        check("R1", int'(burst_ofs), 0);
        rst_n = 1'b1;
        m_tag = "R1";

        // R8: advance before any strobe
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 32'h3_0003);

        // R2 R4 R9 R5: processor strobe, linear, start 2, wrap
        step(1, 0, 0, 0, 32'h2_ABC6);
        for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 32'h1_FFFF);

        // R2 R3 R10: controller strobe, interleaved, start 3, order input toggled
        step(0, 1, 0, 1, 32'h1_2347);
        for (int i = 0; i < 5; i++) step(0, 0, 1, (i % 2 == 0), 0);
        step(0, 0, 0, 0, 0);

        // R3: interleaved from start 1 and 2
        step(1, 1, 0, 1, 32'h0_0011);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 0);
        step(1, 0, 0, 1, 32'h3_FFFE);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 0);

        // R6: strobe and advance together
        step(0, 1, 1, 0, 32'h0_5551);
        step(0, 0, 1, 0, 0);
        step(1, 0, 1, 1, 32'h2_0002);
        step(0, 0, 0, 0, 0);

        // Random stream
        for (int i = 0; i < 600; i++) begin
            int r = $urandom();
            step((r % 11) == 0, ((r >> 4) % 13) == 0, ((r >> 8) % 3) != 0,
                 ((r >> 12) % 5) == 0 ? ~m_inter : m_inter, int'($urandom() % (1 << ADDR_W)));
        end
        step(0, 0, 0, 0, 0);

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule